// File: doc/BRIEF.md
# Descriptor-Driven DMA Channel

This block is one DMA channel that executes a chain of 16-byte descriptors kept in memory. Starting from a pointer supplied by the register block, it reads each descriptor over a 32-bit request/grant memory port. It then streams bytes from memory to a device, streams device bytes into memory, or stores or loads one 32-bit quad. Finally it writes the residual count and a status half-word back into the descriptor.

Every descriptor carries its own opcode and three two-bit conditions. These decide whether completion raises an interrupt, whether the chain jumps, and whether the engine holds before the next fetch. Each condition is tested against an 8-bit channel status through its own mask/value select register. A stop descriptor parks the channel until a wake pulse arrives. Reserved encodings and memory faults park it in a dead state until run is withdrawn.

Top module: `desc_dma_chan`

## Requirements
- R1: A descriptor at pointer P is read as three words at P, P+4 and P+8. Word 0 holds the request count in bits 15:0 and the command in bits 31:16. Word 1 is the data address and word 2 is the command-dependent word. Word 3 at P+12 is written back with the residual in bits 15:0 and the status in bits 31:16.
- R2: Command opcode (bits 15:12) 0 or 1 reads the request count of bytes, starting at the data address and ascending. Each byte is taken from the lane given by the address's low two bits of the little-endian word. One byte is sent per device handshake. `dev_out_last_o` is high only with the final byte of opcode 1.
- R3: Opcodes 2 and 3 write device bytes to ascending addresses, one byte strobe per write. Opcode 3 ends early on the byte flagged by `dev_in_last_i`; opcode 2 ignores that flag.
- R4: The residual written back is the request count minus the bytes moved. The status written back is 8'h80 in its upper byte and `chan_stat_i` in its lower byte.
- R5: Opcode 4 writes the command-dependent word to the word holding the data address, with the low two address bits ignored. Opcode 5 reads that word and writes it into the descriptor's command-dependent field at P+8.
- R6: A condition code (0 never, 1 if true, 2 if false, 3 always) counts "true" when `chan_stat_i` masked by select bits 15:8 equals select bits 7:0.
- R7: When the interrupt condition (command bits 5:4, select `int_sel_i`) holds at write-back, `irq_o` pulses high for exactly one cycle.
- R8: When the branch condition (command bits 3:2, select `br_sel_i`) holds at write-back, the next pointer is the command-dependent word as it stands in memory at that point. Otherwise the pointer advances by 16.
- R9: While the wait condition (command bits 1:0, select `wait_sel_i`) holds after write-back, no further memory request is made and the channel stays active.
- R10: Opcode 7 clears `active_o`, writes nothing back and issues no requests. A `wake_i` pulse re-reads the descriptor at the same pointer.
- R11: Key 4 (command bits 10:8), an opcode above 7, or `mem_err_i` on a granted access raises `dead_o`. After that the channel issues no requests and writes nothing back until `run_i` falls.
- R12: While `pause_i` is high no memory request is presented. A request presented without a grant keeps its address into the next cycle.
- R13: After reset, and whenever `run_i` is low, `active_o`, `dead_o`, `irq_o` and `mem_req_o` are low. Raising `run_i` loads `cmd_ptr_i` and starts fetching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Channel enable; low aborts to idle |
| pause_i | input | 1 | Holds back memory requests |
| wake_i | input | 1 | Restarts a stopped channel |
| cmd_ptr_i | input | AW | First descriptor address |
| chan_stat_i | input | 8 | Channel status bits tested by conditions |
| int_sel_i | input | 16 | Interrupt select: mask 15:8, value 7:0 |
| br_sel_i | input | 16 | Branch select: mask 15:8, value 7:0 |
| wait_sel_i | input | 16 | Wait select: mask 15:8, value 7:0 |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Word-aligned byte address |
| mem_be_o | output | 4 | Byte strobes for writes |
| mem_wdata_o | output | 32 | Write data |
| mem_gnt_i | input | 1 | Grant; completes the access this cycle |
| mem_err_i | input | 1 | Access fault, valid with grant |
| mem_rdata_i | input | 32 | Read data, valid with grant |
| dev_out_valid_o | output | 1 | Outgoing byte valid |
| dev_out_data_o | output | 8 | Outgoing byte |
| dev_out_last_o | output | 1 | Final byte of an output-last command |
| dev_out_ready_i | input | 1 | Device accepts the outgoing byte |
| dev_in_valid_i | input | 1 | Incoming byte valid |
| dev_in_data_i | input | 8 | Incoming byte |
| dev_in_last_i | input | 1 | Device end-of-data flag |
| dev_in_ready_o | output | 1 | Channel accepts an incoming byte |
| irq_o | output | 1 | One-cycle interrupt pulse |
| active_o | output | 1 | Channel is running a chain |
| dead_o | output | 1 | Channel halted on a fault |

## Verification
The bench starts an output transfer at an unaligned address and crosses a word boundary. A design with the wrong byte lane or the wrong count would send wrong bytes, and one that marks every byte as last would fail the scoreboard. Input runs end early on the device flag only for the "last" opcode. A design that honours the flag on input-more, or miscounts the residual, leaves wrong memory bytes or a wrong residual word. Branch is tested in both the taken and the if-false-not-taken directions: a design that inverts the condition either runs a skipped stop descriptor or misses the jump target. Further runs hold the channel with pause and with a true wait condition. They also probe a reserved key and a faulting fetch. A design that leaks a request, a write-back or a restart in those states is caught by request counts and by untouched descriptor words.

// File: rtl/desc_dma_chan.sv
module desc_dma_chan #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          pause_i,
  input  logic          wake_i,
  input  logic [AW-1:0] cmd_ptr_i,
  input  logic [7:0]    chan_stat_i,
  input  logic [15:0]   int_sel_i,
  input  logic [15:0]   br_sel_i,
  input  logic [15:0]   wait_sel_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [3:0]    mem_be_o,
  output logic [31:0]   mem_wdata_o,
  input  logic          mem_gnt_i,
  input  logic          mem_err_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          dev_out_valid_o,
  output logic [7:0]    dev_out_data_o,
  output logic          dev_out_last_o,
  input  logic          dev_out_ready_i,
  input  logic          dev_in_valid_i,
  input  logic [7:0]    dev_in_data_i,
  input  logic          dev_in_last_i,
  output logic          dev_in_ready_o,
  output logic          irq_o,
  output logic          active_o,
  output logic          dead_o
);
  localparam int STRIDE = 16;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_RD, S_OUT, S_IN, S_WR, S_QUAD, S_LQWB, S_WB, S_WAIT, S_STOP, S_DEAD
  } state_t;

  state_t        st, dec_st;
  logic [AW-1:0] ptr, addr;
  logic [31:0]   dep;
  logic [15:0]   cnt, xfer;
  logic [3:0]    op;
  logic [2:0]    key;
  logic [1:0]    ic, bc, wc, fidx;
  logic [7:0]    byte_r;
  logic          last_r, irq_r, req_st;

  wire [AW-1:0] cur     = addr + AW'(xfer);
  wire [15:0]   xfer_nx = xfer + 16'd1;
  wire [15:0]   resid   = cnt - xfer;
  wire          gnt     = mem_req_o && mem_gnt_i;

  function automatic logic cond_hit(input logic [1:0] c, input logic [15:0] sel, input logic [7:0] s);
    logic hit;
    hit = ((s & sel[15:8]) == sel[7:0]);
    case (c)
      2'd0:    return 1'b0;
      2'd1:    return hit;
      2'd2:    return !hit;
      default: return 1'b1;
    endcase
  endfunction

  always_comb begin
    if (key == 3'd4 || op[3]) dec_st = S_DEAD;
    else case (op[2:0])
      3'd0, 3'd1, 3'd2, 3'd3: dec_st = (cnt == 16'd0) ? S_WB : (op[1] ? S_IN : S_RD);
      3'd4, 3'd5:             dec_st = S_QUAD;
      3'd6:                   dec_st = S_WB;
      default:                dec_st = S_STOP;
    endcase
  end

  always_comb begin
    req_st      = 1'b1;
    mem_we_o    = 1'b0;
    mem_be_o    = 4'hF;
    mem_wdata_o = '0;
    mem_addr_o  = '0;
    case (st)
      S_FETCH: mem_addr_o = ptr + AW'({fidx, 2'b00});
      S_RD:    mem_addr_o = {cur[AW-1:2], 2'b00};
      S_WR: begin
        mem_addr_o  = {cur[AW-1:2], 2'b00};
        mem_we_o    = 1'b1;
        mem_be_o    = 4'b0001 << cur[1:0];
        mem_wdata_o = {4{byte_r}};
      end
      S_QUAD: begin
        mem_addr_o  = {addr[AW-1:2], 2'b00};
        mem_we_o    = (op[2:0] == 3'd4);
        mem_wdata_o = dep;
      end
      S_LQWB: begin
        mem_addr_o  = ptr + AW'(8);
        mem_we_o    = 1'b1;
        mem_wdata_o = dep;
      end
      S_WB: begin
        mem_addr_o  = ptr + AW'(12);
        mem_we_o    = 1'b1;
        mem_wdata_o = {8'h80, chan_stat_i, resid};
      end
      default: req_st = 1'b0;
    endcase
  end

  assign mem_req_o       = req_st && !pause_i;
  assign dev_out_valid_o = (st == S_OUT);
  assign dev_out_data_o  = byte_r;
  assign dev_out_last_o  = (st == S_OUT) && (op[2:0] == 3'd1) && (xfer_nx == cnt);
  assign dev_in_ready_o  = (st == S_IN);
  assign irq_o           = irq_r;
  assign dead_o          = (st == S_DEAD);
  assign active_o        = !(st inside {S_IDLE, S_STOP, S_DEAD});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ptr <= '0; addr <= '0; dep <= '0; cnt <= '0; xfer <= '0;
      op <= '0; key <= '0; ic <= '0; bc <= '0; wc <= '0; fidx <= '0;
      byte_r <= '0; last_r <= 1'b0; irq_r <= 1'b0;
    end else begin
      irq_r <= 1'b0;
      if (!run_i) st <= S_IDLE;
      else if (gnt && mem_err_i) st <= S_DEAD;
      else case (st)
        S_IDLE: begin ptr <= cmd_ptr_i; fidx <= '0; st <= S_FETCH; end
        S_FETCH: if (gnt) begin
          fidx <= fidx + 2'd1;
          case (fidx)
            2'd0: begin
              cnt <= mem_rdata_i[15:0];
              op  <= mem_rdata_i[31:28];
              key <= mem_rdata_i[26:24];
              ic  <= mem_rdata_i[21:20];
              bc  <= mem_rdata_i[19:18];
              wc  <= mem_rdata_i[17:16];
            end
            2'd1:    addr <= AW'(mem_rdata_i);
            default: begin dep <= mem_rdata_i; xfer <= '0; st <= dec_st; end
          endcase
        end
        S_RD: if (gnt) begin byte_r <= mem_rdata_i[{cur[1:0], 3'b000} +: 8]; st <= S_OUT; end
        S_OUT: if (dev_out_ready_i) begin
          xfer <= xfer_nx;
          st   <= (xfer_nx == cnt) ? S_WB : S_RD;
        end
        S_IN: if (dev_in_valid_i) begin
          byte_r <= dev_in_data_i;
          last_r <= dev_in_last_i && (op[2:0] == 3'd3);
          st     <= S_WR;
        end
        S_WR: if (gnt) begin
          xfer <= xfer_nx;
          st   <= (xfer_nx == cnt || last_r) ? S_WB : S_IN;
        end
        S_QUAD: if (gnt) begin
          if (!mem_we_o) begin dep <= mem_rdata_i; st <= S_LQWB; end
          else st <= S_WB;
        end
        S_LQWB: if (gnt) st <= S_WB;
        S_WB: if (gnt) begin
          irq_r <= cond_hit(ic, int_sel_i, chan_stat_i);
          ptr   <= cond_hit(bc, br_sel_i, chan_stat_i) ? AW'(dep) : ptr + AW'(STRIDE);
          st    <= S_WAIT;
        end
        S_WAIT: if (!cond_hit(wc, wait_sel_i, chan_stat_i)) begin fidx <= '0; st <= S_FETCH; end
        S_STOP: if (wake_i) begin fidx <= '0; st <= S_FETCH; end
        default: ;
      endcase
    end
  end

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o); // R7
  AST_XFER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st inside {S_RD, S_OUT, S_IN, S_WR}) |-> (xfer < cnt)); // R4
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_gnt_i && run_i) |=> $stable(mem_addr_o)); // R12
  AST_DEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dead_o && run_i) |=> (dead_o && !mem_req_o)); // R11
  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STOP && !wake_i && run_i) |=> (!mem_req_o && !active_o)); // R10
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_out_valid_o && !dev_out_ready_i && run_i) |=> (dev_out_valid_o && $stable(dev_out_data_o))); // R2
endmodule

// File: tb/desc_dma_chan_tb.sv
`timescale 1ns/1ps
module desc_dma_chan_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        run_i = 0, pause_i = 0, wake_i = 0;
  logic [31:0] cmd_ptr_i = '0;
  logic [7:0]  chan_stat_i = '0;
  logic [15:0] int_sel_i = '0, br_sel_i = '0, wait_sel_i = '0;
  logic        mem_req_o, mem_we_o, mem_gnt_i = 1'b0, mem_err_i;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic [3:0]  mem_be_o;
  logic        dev_out_valid_o, dev_out_last_o, dev_out_ready_i = 1'b1;
  logic [7:0]  dev_out_data_o, dev_in_data_i = '0;
  logic        dev_in_valid_i = 1'b0, dev_in_last_i = 1'b0, dev_in_ready_o;
  logic        irq_o, active_o, dead_o;

  desc_dma_chan u_dut (.*);

  logic [31:0] mem [0:255];
  logic        bd_we = 1'b0;
  logic [31:0] bd_a = '0, bd_d = '0;
  logic        gnt_slow = 1'b0, err_en = 1'b0, in_sent = 1'b0;
  logic [7:0]  err_word = '0;
  logic [8:0]  exp_q[$], in_q[$];
  int n_chk = 0, n_fail = 0, irq_cnt = 0, req_cnt = 0;
  bit done = 0;

  assign mem_rdata_i = mem[mem_addr_o[9:2]];
  assign mem_err_i   = err_en && (mem_addr_o[9:2] == err_word);

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= '0;
    end else if (mem_req_o && mem_gnt_i && mem_we_o) begin
      for (int b = 0; b < 4; b++)
        if (mem_be_o[b]) mem[mem_addr_o[9:2]][8*b +: 8] <= mem_wdata_o[8*b +: 8];
    end else if (bd_we) begin
      mem[bd_a[9:2]] <= bd_d;
    end
  end

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  // monitor side of the scoreboard, plus device input driver and grant model
  always @(negedge clk) begin
    mem_gnt_i = gnt_slow ? ~mem_gnt_i : 1'b1;
    if (irq_o) irq_cnt++;
    if (mem_req_o) req_cnt++;
    if (dev_out_valid_o && dev_out_ready_i) begin
      if (exp_q.size() == 0) chk("R2 unexpected byte", {23'd0, dev_out_last_o, dev_out_data_o}, 32'h1FF);
      else chk("R2 byte/last", {23'd0, dev_out_last_o, dev_out_data_o}, {23'd0, exp_q.pop_front()});
    end
    if (in_sent) in_q.delete(0);
    if (in_q.size() > 0) begin
      dev_in_valid_i = 1'b1;
      {dev_in_last_i, dev_in_data_i} = in_q[0];
    end else begin
      dev_in_valid_i = 1'b0;
      dev_in_last_i  = 1'b0;
    end
    in_sent = dev_in_valid_i && dev_in_ready_o;
  end

  function automatic logic [31:0] rd(logic [31:0] a);
    return mem[a[9:2]];
  endfunction

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic poke(logic [31:0] a, logic [31:0] d);
    @(negedge clk); bd_a = a; bd_d = d; bd_we = 1'b1;
    @(negedge clk); bd_we = 1'b0;
  endtask

  task automatic desc(logic [31:0] base, logic [3:0] op, logic [2:0] key, logic [1:0] ic,
                      logic [1:0] bc, logic [1:0] wc, logic [15:0] cnt, logic [31:0] a, logic [31:0] dep);
    poke(base,      {op, 1'b0, key, 2'b00, ic, bc, wc, cnt});
    poke(base + 4,  a);
    poke(base + 8,  dep);
    poke(base + 12, 32'h0);
  endtask

  task automatic push_out(logic last, logic [7:0] b);
    exp_q.push_back({last, b});
  endtask

  task automatic start(logic [31:0] p);
    @(negedge clk); cmd_ptr_i = p; run_i = 1'b1;
    step(1);
  endtask

  task automatic wait_stop(string r);
    int k = 0;
    while (active_o && k < 3000) begin step(1); k++; end
    if (k >= 3000) chk({r, " channel never halted"}, 32'h1, 32'h0);
  endtask

  task automatic halt();
    @(negedge clk); run_i = 1'b0;
    step(2);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int r0;
    step(3);
    rst_n = 1'b1;
    step(2);
    chk("R13 reset active", active_o, 0);
    chk("R13 reset dead",   dead_o,   0);
    chk("R13 reset irq",    irq_o,    0);
    chk("R13 reset req",    mem_req_o, 0);

    // output chain, unaligned, crossing a word, then stop
    poke(32'h100, 32'h44332211);
    poke(32'h104, 32'h88776655);
    desc(32'h000, 4'd0, 3'd6, 2'd0, 2'd0, 2'd0, 16'd3, 32'h101, 32'h0);
    desc(32'h010, 4'd1, 3'd6, 2'd3, 2'd0, 2'd0, 16'd2, 32'h106, 32'h0);
    desc(32'h020, 4'd7, 3'd6, 2'd0, 2'd0, 2'd0, 16'd0, 32'h0,   32'h0);
    push_out(0, 8'h22); push_out(0, 8'h33); push_out(0, 8'h44);
    push_out(0, 8'h77); push_out(1, 8'h88);
    start(32'h000);
    chk("R13 run starts channel", active_o, 1);
    wait_stop("R10");
    chk("R2 all bytes sent", exp_q.size(), 0);
    chk("R1 R4 write-back desc0", rd(32'h00C), 32'h8000_0000);
    chk("R4 write-back desc1", rd(32'h01C), 32'h8000_0000);
    chk("R7 one interrupt", irq_cnt, 1);
    chk("R10 stop writes nothing", rd(32'h02C), 32'h0);
    r0 = req_cnt; step(10);
    chk("R10 no requests when stopped", req_cnt - r0, 0);
    chk("R10 not dead", dead_o, 0);

    // wake re-reads the stop slot
    desc(32'h020, 4'd6, 3'd6, 2'd3, 2'd0, 2'd0, 16'd0, 32'h0, 32'h0);
    desc(32'h030, 4'd7, 3'd6, 2'd0, 2'd0, 2'd0, 16'd0, 32'h0, 32'h0);
    @(negedge clk); wake_i = 1'b1;
    @(negedge clk); wake_i = 1'b0;
    step(1);
    wait_stop("R10");
    chk("R10 wake refetch wrote back", rd(32'h02C), 32'h8000_0000);
    chk("R7 second interrupt", irq_cnt, 2);
    halt();
    chk("R13 run low active", active_o, 0);

    // input chain with slow grants
    gnt_slow = 1'b1;
    poke(32'h200, 32'hAAAAAAAA); poke(32'h210, 32'hAAAAAAAA); poke(32'h214, 32'hAAAAAAAA);
    desc(32'h040, 4'd2, 3'd6, 2'd0, 2'd0, 2'd0, 16'd2, 32'h200, 32'h0);
    desc(32'h050, 4'd3, 3'd6, 2'd0, 2'd0, 2'd0, 16'd6, 32'h210, 32'h0);
    desc(32'h060, 4'd7, 3'd6, 2'd0, 2'd0, 2'd0, 16'd0, 32'h0,   32'h0);
    in_q.push_back({1'b1, 8'h01}); in_q.push_back({1'b0, 8'h02});
    in_q.push_back({1'b0, 8'h03}); in_q.push_back({1'b0, 8'h04}); in_q.push_back({1'b1, 8'h05});
    start(32'h040);
    wait_stop("R3");
    chk("R3 input-more ignores end flag", rd(32'h200), 32'hAAAA0201);
    chk("R3 input-last early end", rd(32'h210), 32'hAA050403);
    chk("R3 bytes past end untouched", rd(32'h214), 32'hAAAAAAAA);
    chk("R3 device bytes consumed", in_q.size(), 0);
    chk("R4 residual zero", rd(32'h04C), 32'h8000_0000);
    chk("R4 residual after early end", rd(32'h05C), 32'h8000_0003);
    halt();
    gnt_slow = 1'b0;

    // branch and quad commands
    chan_stat_i = 8'h5A;
    br_sel_i = 16'hF050;
    poke(32'h310, 32'h12345678);
    desc(32'h080, 4'd6, 3'd6, 2'd0, 2'd1, 2'd0, 16'd0, 32'h0,   32'h0C0);
    desc(32'h090, 4'd7, 3'd6, 2'd0, 2'd0, 2'd0, 16'd0, 32'h0,   32'h0);
    desc(32'h0C0, 4'd4, 3'd6, 2'd0, 2'd2, 2'd0, 16'd0, 32'h303, 32'hDEADBEEF);
    desc(32'h0D0, 4'd5, 3'd6, 2'd0, 2'd0, 2'd0, 16'd0, 32'h310, 32'h0);
    desc(32'h0E0, 4'd7, 3'd6, 2'd0, 2'd0, 2'd0, 16'd0, 32'h0,   32'h0);
    start(32'h080);
    wait_stop("R8");
    chk("R4 status carries channel bits", rd(32'h08C), 32'h805A_0000);
    chk("R8 taken branch skips next slot", rd(32'h09C), 32'h0);
    chk("R8 branch target executed", rd(32'h0CC), 32'h805A_0000);
    chk("R5 store-quad", rd(32'h300), 32'hDEADBEEF);
    chk("R6 if-false with true cond falls through", rd(32'h0DC), 32'h805A_0000);
    chk("R5 load-quad into descriptor", rd(32'h0D8), 32'h12345678);
    halt();
    br_sel_i = '0;

    // pause, then wait condition
    chan_stat_i = 8'h01;
    wait_sel_i  = 16'h0101;
    pause_i = 1'b1;
    desc(32'h140, 4'd6, 3'd6, 2'd0, 2'd0, 2'd1, 16'd0, 32'h0, 32'h0);
    desc(32'h150, 4'd7, 3'd6, 2'd0, 2'd0, 2'd0, 16'd0, 32'h0, 32'h0);
    start(32'h140);
    r0 = req_cnt; step(20);
    chk("R12 no request while paused", req_cnt - r0, 0);
    chk("R12 paused channel active", active_o, 1);
    pause_i = 1'b0;
    for (int k = 0; k < 200 && rd(32'h14C) == 0; k++) step(1);
    step(2);
    r0 = req_cnt; step(30);
    chk("R9 no fetch while wait holds", req_cnt - r0, 0);
    chk("R9 active while waiting", active_o, 1);
    chan_stat_i = 8'h00;
    step(1);
    wait_stop("R9");
    chk("R9 resumed to stop", {dead_o, active_o}, 2'b00);
    halt();
    wait_sel_i = '0;

    // reserved key
    desc(32'h180, 4'd6, 3'd4, 2'd3, 2'd0, 2'd0, 16'd0, 32'h0, 32'h0);
    start(32'h180);
    step(10);
    chk("R11 reserved key dead", dead_o, 1);
    chk("R11 dead not active", active_o, 0);
    r0 = req_cnt; step(10);
    chk("R11 no requests when dead", req_cnt - r0, 0);
    chk("R11 no write-back when dead", rd(32'h18C), 32'h0);
    halt();
    chk("R13 run low clears dead", dead_o, 0);

    // memory fault on second descriptor word
    desc(32'h1C0, 4'd0, 3'd6, 2'd0, 2'd0, 2'd0, 16'd1, 32'h100, 32'h0);
    err_word = 8'h71;
    err_en = 1'b1;
    start(32'h1C0);
    step(10);
    chk("R11 memory error dead", dead_o, 1);
    chk("R11 no write-back after error", rd(32'h1CC), 32'h0);
    halt();
    err_en = 1'b0;
    chk("R13 dead cleared", dead_o, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule